// File: doc/BRIEF.md
# Dual-Format Radix-4 Booth Multiplier

A purely combinational 8-by-8 integer multiplier that serves both two's-complement and unsigned operands with one array. A single mode input decides how the top bit of each operand is read. Each operand is widened by two bits. In signed mode the two new bits copy the operand's top bit. In unsigned mode they are zero. Because of this widening, one Booth array covers both number formats.

The widened multiplier is recoded in radix 4 into five digits, each in the set {-2, -1, 0, +1, +2}. Every digit selects a row: zero, the widened multiplicand, or twice it. A negative row is inverted, and a correction bit is added at that row's lowest weight. The five rows and the vector of correction bits pass through three levels of carry-save adders, which leave two vectors. A two-level carry-lookahead adder then forms the 16-bit product.

The result follows its inputs in the same cycle. The block has no clock and holds no state.

Top module: `booth_mul`

## Requirements
- R1: With `is_signed`=1, `product` equals the low 16 bits of the two's-complement product of `mcand` and `mplier`. For example, -128 × -128 gives 0x4000 and -128 × 127 gives 0xC080.
- R2: With `is_signed`=0, `product` equals the unsigned product of the two operands. For example, 255 × 255 gives 0xFE01 and 0x80 × 0x80 gives 0x4000.
- R3: Each operand is widened to 10 bits. Its bits 8 and 9 equal `is_signed` AND its bit 7, so in unsigned mode the widening bits are zero. As a result, operands 0xFF and 0xFF give 0x0001 in signed mode and 0xFE01 in unsigned mode.
- R4: The multiplier triple (b[2k+1], b[2k], b[2k-1]) is recoded into digit k with weight 4^k, and the bit below b[0] is 0. The mapping is 000→0, 001→+1, 010→+1, 011→+2, 100→-2, 101→-1, 110→-1, 111→0. Each row selects at most one of the ×1 and ×2 multiples. Every multiplier low nibble, 0 to 15, gives the exact product in both modes.
- R5: The negate flag of a row is raised only for the triples 100, 101 and 110. The row is then the bitwise inverse of its multiple, plus 1 added at bit 2k. A row whose digit is zero is never negated.
- R6: The fifth row, taken from widened bits 9, 8 and 7, contributes +2^8 × multiplicand in unsigned mode when bit 7 of the multiplier is set. In signed mode it contributes nothing. For example, 0x03 × 0x80 gives 0x0180 unsigned and 0xFE80 signed.
- R7: The six operands (five rows and the correction-bit vector) are reduced to two vectors by three carry-save levels. The final sum is formed by 4-bit lookahead groups, joined by a group-level lookahead, and is correct even when a carry crosses every group.
- R8: If either operand is zero, `product` is 0x0000 in both modes.
- R9: A change of `is_signed` alone, with both operands held, changes `product` to the value of the new mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mcand | input | 8 | Multiplicand |
| mplier | input | 8 | Multiplier; this operand is Booth recoded |
| is_signed | input | 1 | 1: two's-complement operands; 0: unsigned operands |
| product | output | 16 | Full-width product |

## Verification
A wrong internal state appears at `product` in the same evaluation as the input that exposes it. The block holds nothing, so a fault cannot stay hidden until a later cycle. A mis-recoded triple or a dropped correction bit corrupts the value by a multiple of 4^k. Such a fault shows only for multipliers whose triple k takes the bad code, so the low-nibble scan and the strided sweep cover every code in every row position. A broken widening bit or a faulty fifth row shows only when bit 7 of an operand is set, which the mode-flip and corner tests target. A fault in a lookahead group shows when a carry must cross that group, as in 255 × 255.

// File: rtl/booth_mul_pkg.sv
package booth_mul_pkg;

  // One recoded radix-4 digit: sign flag plus a one-hot choice of multiple
  typedef struct packed {
    logic neg;
    logic one;
    logic two;
  } bdig_t;

  // Triple order is {upper, middle, lower}; digit = -2*upper + middle + lower
  function automatic bdig_t recode(input logic [2:0] t);
    bdig_t d;
    d.one = t[1] ^ t[0];
    d.two = (t == 3'b011) || (t == 3'b100);
    d.neg = t[2] & ~(t[1] & t[0]);
    return d;
  endfunction

  // Number of 3:2 levels needed to bring n operands down to two
  function automatic int csa_levels(input int n);
    int cnt;
    int k;
    cnt = 0;
    k = n;
    while (k > 2) begin
      k = (k / 3) * 2 + (k % 3);
      cnt++;
    end
    return cnt;
  endfunction

endpackage

// File: rtl/bm_rowgen.sv
module bm_rowgen
  import booth_mul_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0]                 a,
  input  logic [N-1:0]                 b,
  input  logic                         sgn,
  output logic [(N+2)/2-1:0][2*N-1:0]  rows,
  output logic [2*N-1:0]               negrow,
  output logic [(N+2)/2-1:0]           dneg,
  output logic [(N+2)/2-1:0]           done,
  output logic [(N+2)/2-1:0]           dtwo
);
  localparam int EW   = N + 2;
  localparam int ROWS = EW / 2;
  localparam int PW   = 2 * N;
  localparam int RW   = EW + 1;

  logic [EW-1:0] a_ext;
  logic [EW:0]   b_pad;

  assign a_ext = {{2{sgn & a[N-1]}}, a};
  assign b_pad = {{2{sgn & b[N-1]}}, b, 1'b0};

  for (genvar k = 0; k < ROWS; k++) begin : g_row
    bdig_t         d;
    logic [RW-1:0] mult;
    logic [RW-1:0] inv;
    logic [PW-1:0] wide;

    assign d    = recode(b_pad[2*k+2 -: 3]);
    assign mult = d.two ? {a_ext, 1'b0} :
                  d.one ? {a_ext[EW-1], a_ext} : '0;
    assign inv  = mult ^ {RW{d.neg}};
    assign wide = {{(PW-RW){inv[RW-1]}}, inv};
    assign rows[k] = wide << (2 * k);
    assign dneg[k] = d.neg;
    assign done[k] = d.one;
    assign dtwo[k] = d.two;
  end

  always_comb begin
    negrow = '0;
    for (int k = 0; k < ROWS; k++) begin
      negrow[2*k] = dneg[k];
    end
  end

endmodule

// File: rtl/bm_csa_tree.sv
module bm_csa_tree
  import booth_mul_pkg::*;
#(
  parameter int PW   = 16,
  parameter int ROWS = 5
) (
  input  logic [ROWS-1:0][PW-1:0] rows,
  input  logic [PW-1:0]           negrow,
  output logic [PW-1:0]           sum,
  output logic [PW-1:0]           carry
);
  localparam int OPS    = ROWS + 1;
  localparam int LEVELS = csa_levels(OPS);

  logic [PW-1:0] cur [OPS];
  logic [PW-1:0] nxt [OPS];
  int n;
  int m;

  always_comb begin
    for (int i = 0; i < ROWS; i++) cur[i] = rows[i];
    cur[ROWS] = negrow;
    for (int i = 0; i < OPS; i++) nxt[i] = '0;
    n = OPS;
    m = 0;
    for (int l = 0; l < LEVELS; l++) begin
      for (int i = 0; i < OPS; i++) nxt[i] = '0;
      m = 0;
      for (int i = 0; i < OPS; i += 3) begin
        if (i + 2 < n) begin
          nxt[m]   = cur[i] ^ cur[i+1] ^ cur[i+2];
          nxt[m+1] = ((cur[i] & cur[i+1]) | (cur[i] & cur[i+2]) |
                      (cur[i+1] & cur[i+2])) << 1;
          m = m + 2;
        end else if (i < n) begin
          nxt[m] = cur[i];
          m = m + 1;
          if (i + 1 < n) begin
            nxt[m] = cur[i+1];
            m = m + 1;
          end
        end
      end
      for (int i = 0; i < OPS; i++) cur[i] = nxt[i];
      n = m;
    end
    sum   = cur[0];
    carry = cur[1];
  end

endmodule

// File: rtl/bm_cla.sv
module bm_cla #(
  parameter int W  = 16,
  parameter int GW = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] s
);
  localparam int NG = W / GW;

  logic [W-1:0]  p;
  logic [W-1:0]  g;
  logic [NG-1:0] gp;
  logic [NG-1:0] gg;
  logic [NG-1:0] gc;
  logic [W-1:0]  c;

  assign p = x ^ y;
  assign g = x & y;

  // Group propagate / generate in sum-of-products form
  always_comb begin
    for (int j = 0; j < NG; j++) begin
      logic t;
      gp[j] = &p[j*GW +: GW];
      gg[j] = 1'b0;
      for (int i = 0; i < GW; i++) begin
        t = g[j*GW+i];
        for (int k = i + 1; k < GW; k++) t = t & p[j*GW+k];
        gg[j] = gg[j] | t;
      end
    end
  end

  // Second-level lookahead: carry into each group, no group-to-group ripple
  always_comb begin
    for (int j = 0; j < NG; j++) begin
      logic t;
      gc[j] = 1'b0;
      for (int i = 0; i < j; i++) begin
        t = gg[i];
        for (int k = i + 1; k < j; k++) t = t & gp[k];
        gc[j] = gc[j] | t;
      end
    end
  end

  // Bit carries inside each group from the group carry-in
  always_comb begin
    for (int j = 0; j < NG; j++) begin
      for (int b = 0; b < GW; b++) begin
        logic acc;
        logic t;
        acc = gc[j];
        for (int k = 0; k < b; k++) acc = acc & p[j*GW+k];
        for (int i = 0; i < b; i++) begin
          t = g[j*GW+i];
          for (int k = i + 1; k < b; k++) t = t & p[j*GW+k];
          acc = acc | t;
        end
        c[j*GW+b] = acc;
      end
    end
  end

  assign s = p ^ c;

endmodule

// File: rtl/booth_mul.sv
module booth_mul
  import booth_mul_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0]   mcand,
  input  logic [N-1:0]   mplier,
  input  logic           is_signed,
  output logic [2*N-1:0] product
);
  localparam int ROWS = (N + 2) / 2;
  localparam int PW   = 2 * N;

  logic [ROWS-1:0][PW-1:0] pp_rows;
  logic [PW-1:0]           pp_negrow;
  logic [ROWS-1:0]         row_neg;
  logic [ROWS-1:0]         row_one;
  logic [ROWS-1:0]         row_two;
  logic [PW-1:0]           csa_sum;
  logic [PW-1:0]           csa_carry;

  bm_rowgen #(.N(N)) u_rows (
    .a      (mcand),
    .b      (mplier),
    .sgn    (is_signed),
    .rows   (pp_rows),
    .negrow (pp_negrow),
    .dneg   (row_neg),
    .done   (row_one),
    .dtwo   (row_two)
  );

  bm_csa_tree #(.PW(PW), .ROWS(ROWS)) u_tree (
    .rows   (pp_rows),
    .negrow (pp_negrow),
    .sum    (csa_sum),
    .carry  (csa_carry)
  );

  bm_cla #(.W(PW), .GW(4)) u_cla (
    .x (csa_sum),
    .y (csa_carry),
    .s (product)
  );

endmodule

// File: rtl/booth_mul_chk.sv
module booth_mul_chk #(
  parameter int N = 8
) (
  input logic [N-1:0]         mcand,
  input logic [N-1:0]         mplier,
  input logic                 is_signed,
  input logic [2*N-1:0]       product,
  input logic [(N+2)/2-1:0]   row_neg,
  input logic [(N+2)/2-1:0]   row_one,
  input logic [(N+2)/2-1:0]   row_two,
  input logic [2*N-1:0]       csa_sum,
  input logic [2*N-1:0]       csa_carry
);
  localparam int ROWS = (N + 2) / 2;

  logic signed [2*N+1:0] ea;
  logic signed [2*N+1:0] eb;
  logic signed [2*N+1:0] full;
  logic [2*N-1:0]        expect_p;

  always_comb begin
    ea = is_signed ? {{(N+2){mcand[N-1]}}, mcand}  : {{(N+2){1'b0}}, mcand};
    eb = is_signed ? {{(N+2){mplier[N-1]}}, mplier} : {{(N+2){1'b0}}, mplier};
    full = ea * eb;
    expect_p = full[2*N-1:0];
  end

  always_comb begin
    if (is_signed) begin
      p_signed_prod_r1: assert (product == expect_p) else $error("R1 signed product mismatch");
    end else begin
      p_unsigned_prod_r2: assert (product == expect_p) else $error("R2 unsigned product mismatch");
    end
    // R3: unsigned widening is zero, so the top digit is never negative
    if (!is_signed) begin
      p_top_row_pos_r3: assert (!row_neg[ROWS-1]) else $error("R3 top row negated in unsigned mode");
    end
    for (int k = 0; k < ROWS; k++) begin
      p_one_multiple_r4: assert ($onehot0({row_one[k], row_two[k]})) else $error("R4 two multiples chosen");
      p_neg_nonzero_r5: assert (!row_neg[k] || row_one[k] || row_two[k]) else $error("R5 zero digit negated");
    end
    p_final_add_r7: assert (product == csa_sum + csa_carry) else $error("R7 final adder mismatch");
    if (mcand == '0 || mplier == '0) begin
      p_zero_operand_r8: assert (product == '0) else $error("R8 nonzero product from zero operand");
    end
  end

endmodule

bind booth_mul booth_mul_chk #(.N(N)) u_chk (
  .mcand     (mcand),
  .mplier    (mplier),
  .is_signed (is_signed),
  .product   (product),
  .row_neg   (row_neg),
  .row_one   (row_one),
  .row_two   (row_two),
  .csa_sum   (csa_sum),
  .csa_carry (csa_carry)
);

// File: tb/sim_booth_mul.sv
`timescale 1ns/1ps
module sim_booth_mul;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] ta = '0;
  logic [7:0] tb = '0;
  logic       tm = 1'b0;
  logic [15:0] tp;
  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  booth_mul u0 (.mcand(ta), .mplier(tb), .is_signed(tm), .product(tp));

  function automatic logic [15:0] ref_prod(input logic [7:0] a, input logic [7:0] b, input logic m);
    int ia;
    int ib;
    int pr;
    ia = (m && a[7]) ? int'(a) - 256 : int'(a);
    ib = (m && b[7]) ? int'(b) - 256 : int'(b);
    pr = ia * ib;
    return pr[15:0];
  endfunction

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=0x%04h expected=0x%04h (a=0x%02h b=0x%02h signed=%0d)",
               req, got, exp, ta, tb, tm);
    end
  endtask

  task automatic apply(input logic [7:0] a, input logic [7:0] b, input logic m);
    @(posedge clk);
    #1;
    ta = a;
    tb = b;
    tm = m;
    @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R8 idle", tp, 16'h0000);
  endtask

  task automatic t_corners;
    apply(8'h80, 8'h80, 1'b1); check("R1", tp, 16'h4000);
    apply(8'h80, 8'h7F, 1'b1); check("R1", tp, 16'hC080);
    apply(8'hFF, 8'hFF, 1'b0); check("R2", tp, 16'hFE01);
    apply(8'h80, 8'h80, 1'b0); check("R2", tp, 16'h4000);
    apply(8'h7F, 8'h7F, 1'b1); check("R1", tp, 16'h3F01);
  endtask

  task automatic t_extension;
    apply(8'hFF, 8'hFF, 1'b1); check("R3", tp, 16'h0001);
    apply(8'hFF, 8'hFF, 1'b0); check("R3", tp, 16'hFE01);
    apply(8'h03, 8'h80, 1'b0); check("R6", tp, 16'h0180);
    apply(8'h03, 8'h80, 1'b1); check("R6", tp, 16'hFE80);
  endtask

  task automatic t_digits;
    for (int m = 0; m < 2; m++) begin
      for (int b = 0; b < 16; b++) begin
        apply(8'h5B, 8'(b), 1'(m));
        check("R4", tp, ref_prod(8'h5B, 8'(b), 1'(m)));
        apply(8'hA6, 8'(b << 4), 1'(m));
        check("R5", tp, ref_prod(8'hA6, 8'(b << 4), 1'(m)));
      end
    end
  endtask

  task automatic t_zero;
    apply(8'h00, 8'hC3, 1'b1); check("R8", tp, 16'h0000);
    apply(8'h9D, 8'h00, 1'b0); check("R8", tp, 16'h0000);
    apply(8'h00, 8'h00, 1'b1); check("R8", tp, 16'h0000);
  endtask

  task automatic t_mode_flip;
    apply(8'hC8, 8'h35, 1'b0); check("R9", tp, ref_prod(8'hC8, 8'h35, 1'b0));
    apply(8'hC8, 8'h35, 1'b1); check("R9", tp, ref_prod(8'hC8, 8'h35, 1'b1));
    apply(8'h81, 8'hFE, 1'b1); check("R9", tp, ref_prod(8'h81, 8'hFE, 1'b1));
    apply(8'h81, 8'hFE, 1'b0); check("R9", tp, ref_prod(8'h81, 8'hFE, 1'b0));
  endtask

  task automatic t_carry_chain;
    apply(8'hFF, 8'h01, 1'b0); check("R7", tp, 16'h00FF);
    apply(8'hFF, 8'h01, 1'b1); check("R7", tp, 16'hFFFF);
    apply(8'hF1, 8'h11, 1'b0); check("R7", tp, 16'h1001);
  endtask

  task automatic t_sweep;
    for (int m = 0; m < 2; m++) begin
      for (int a = 0; a < 256; a++) begin
        for (int b = 0; b < 256; b += 3) begin
          apply(8'(a), 8'(b), 1'(m));
          check(m ? "R1 sweep" : "R2 sweep", tp, ref_prod(8'(a), 8'(b), 1'(m)));
        end
      end
    end
  endtask

  initial begin
    #1_500_000;
    bad++;
    total++;
    $display("FAIL watchdog: got=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset;
    t_corners;
    t_extension;
    t_digits;
    t_zero;
    t_mode_flip;
    t_carry_chain;
    t_sweep;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule